// File: doc/BRIEF.md
# Serial Audio Receiver (I2S and PCM framing)

This block receives a serial audio stream made of a bit clock, a word-select (or frame-sync) line and one of several serial data lines, and turns it into parallel sample words. The three serial inputs are brought into the system clock domain through synchronizers. Each rising edge of the bit clock is then found by edge detection, and the data line is read at that point. A slot controller follows the word edges and counts bit positions from the edge. It opens a capture window that starts a programmable number of bit clocks after the edge and lasts for the selected precision. An assembler shifts the window's bits in MSB first and sign-extends the finished sample to 32 bits.

A 32-bit attribute word sets the framing. It selects I2S (two slots, left while word-select is low, right while it is high) or PCM (a one-bit-clock sync pulse per frame and one 16-bit sample). It also selects 16-bit or 24-bit precision, mono or stereo, the offset between the word edge and the first data bit, and which serial data line is sampled. A receive-enable input gates the block. After it is raised, capture waits for the next word edge so that no partial sample is ever delivered. Each sample leaves as a one-cycle valid pulse with the data word and a channel flag.

Top module: `serial_audio_rx`

## Requirements
- R1: Attribute bits [1:0] choose the framing: 2'b01 is PCM and every other value is I2S. In PCM a frame starts at a bit-clock rising edge where word-select is high after being low, one sample is delivered per frame, and the channel flag is always 0.
- R2: In I2S mode attribute bits [3:2] = 2'b10 select 24-bit samples, and any other value selects 16-bit samples. PCM always uses 16 bits, whatever that field holds. Every delivered word is the sample sign-extended to 32 bits.
- R3: Attribute bits [6:4] = 3'b001 select mono, and any other value selects stereo. In stereo, the slot started with word-select low is delivered with out_right=0 and the slot started with word-select high with out_right=1. In mono, only the word-select-low slot is delivered.
- R4: Attribute bits [15:8] give the offset N. The sample MSB is the bit read at the N-th bit-clock rising edge after the word edge, where N=0 is the edge itself and N=1 is standard I2S.
- R5: Attribute bits [23:20] index the serial data line. An index at or above the number of lines reads constant 0.
- R6: While rx_en is low nothing is delivered. After rx_en rises, capture begins only at the next word edge.
- R7: Bits of a slot that lie outside the capture window do not affect the delivered word.
- R8: Data is shifted in MSB first, and out_valid never stays high for two cycles in a row.
- R9: A synchronous active-high reset clears out_valid, out_data and out_right.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| rx_attr | input | 32 | Interface attribute word (framing, precision, channels, offset, source) |
| sck | input | 1 | Serial bit clock, asynchronous |
| ws | input | 1 | Word-select in I2S mode, frame-sync in PCM mode |
| sd | input | NUM_LINES | Serial data lines |
| out_valid | output | 1 | One-cycle pulse per delivered sample |
| out_data | output | 32 | Sign-extended sample |
| out_right | output | 1 | Channel flag: 1 for the word-select-high slot |

## Verification
The assertions watch, on every cycle, the properties that can be seen from the ports alone. They check that valid is a single-cycle pulse, that nothing appears while rx_en is low, that the flag stays 0 in mono and PCM, and that each word is a proper sign extension of a 16-bit or 24-bit sample. Only the bench scenarios can show that the right bits are picked. That covers the word value under each offset and precision, MSB-first order, that junk outside the window is ignored, the source line selection and the wait for a word edge after enabling. For these the bench sends known samples and compares every delivered word.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

  localparam int ATTR_W = 32;

  // decoded receive configuration
  typedef struct packed {
    logic       pcm;     // PCM framing
    logic       wide;    // 24-bit request (ignored in PCM)
    logic       mono;    // deliver the low slot only
    logic [7:0] offset;  // bit clocks from word edge to MSB
    logic [3:0] src;     // serial data line index
  } rx_cfg_t;

  function automatic rx_cfg_t decode_attr(input logic [ATTR_W-1:0] a);
    rx_cfg_t c;
    c.pcm    = (a[1:0] == 2'b01);
    c.wide   = (a[3:2] == 2'b10);
    c.mono   = (a[6:4] == 3'b001);
    c.offset = a[15:8];
    c.src    = a[23:20];
    return c;
  endfunction

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q[s] <= '0;
        end else if (s == 0) begin
          stage_q[s] <= din;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/sarx_slot_ctrl.sv
module sarx_slot_ctrl
  import sarx_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int LO_W  = 16,
  parameter int HI_W  = 24
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    tick,       // bit clock rising edge seen this cycle
  input  logic    ws_s,       // synchronized word-select
  input  logic    en,
  input  rx_cfg_t cfg,
  output logic    cap,        // take the data bit this cycle
  output logic    last,       // this bit completes the sample
  output logic    slot_high   // slot began with word-select high
);

  logic             ws_prev_q;
  logic             locked_q;
  logic             ch_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] rel;
  logic [CNT_W-1:0] off_ext;
  logic [CNT_W-1:0] prec_len;
  logic             edge_hit;
  logic             active;
  logic             in_win;

  always_comb begin
    if (cfg.pcm) edge_hit = tick & ws_s & ~ws_prev_q;
    else         edge_hit = tick & (ws_s ^ ws_prev_q);
  end

  always_comb begin
    if (edge_hit)          pos = '0;
    else if (&cnt_q)       pos = cnt_q;
    else                   pos = cnt_q + 1'b1;
  end

  assign off_ext  = CNT_W'(cfg.offset);
  assign prec_len = (cfg.wide && !cfg.pcm) ? CNT_W'(HI_W) : CNT_W'(LO_W);
  assign rel      = pos - off_ext;
  assign in_win   = (pos >= off_ext) && (rel < prec_len);
  assign active   = en & (locked_q | edge_hit);

  assign cap       = tick & active & in_win;
  assign last      = cap & (rel == prec_len - 1'b1);
  assign slot_high = edge_hit ? ws_s : ch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_prev_q <= 1'b0;
      locked_q  <= 1'b0;
      ch_q      <= 1'b0;
      cnt_q     <= '0;
    end else begin
      if (!en)           locked_q <= 1'b0;
      else if (edge_hit) locked_q <= 1'b1;
      if (tick) begin
        ws_prev_q <= ws_s;
        cnt_q     <= pos;
      end
      if (edge_hit) ch_q <= ws_s;
    end
  end

endmodule

// File: rtl/sarx_assembler.sv
module sarx_assembler #(
  parameter int DATA_W = 32,
  parameter int LO_W   = 16,
  parameter int HI_W   = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic              last,
  input  logic              bit_in,
  input  logic              wide,
  input  logic              emit_ok,
  input  logic              chan,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_right
);

  logic [HI_W-1:0]   sh_q;
  logic [HI_W-1:0]   nxt;
  logic [DATA_W-1:0] word_lo;
  logic [DATA_W-1:0] word_hi;

  assign nxt     = {sh_q[HI_W-2:0], bit_in};
  assign word_lo = {{(DATA_W-LO_W){nxt[LO_W-1]}}, nxt[LO_W-1:0]};
  assign word_hi = {{(DATA_W-HI_W){nxt[HI_W-1]}}, nxt};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_right <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (cap) sh_q <= nxt;
      if (last && emit_ok) begin
        out_valid <= 1'b1;
        out_data  <= wide ? word_hi : word_lo;
        out_right <= chan;
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int NUM_LINES   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 9,
  parameter int LO_W        = 16,
  parameter int HI_W        = 24,
  parameter int DATA_W      = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_en,
  input  logic [ATTR_W-1:0]    rx_attr,
  input  logic                 sck,
  input  logic                 ws,
  input  logic [NUM_LINES-1:0] sd,
  output logic                 out_valid,
  output logic [DATA_W-1:0]    out_data,
  output logic                 out_right
);

  localparam int SYNC_W = NUM_LINES + 2;

  rx_cfg_t              cfg;
  logic [SYNC_W-1:0]    sync_out;
  logic                 sck_s;
  logic                 ws_s;
  logic [NUM_LINES-1:0] sd_s;
  logic                 sck_d_q;
  logic                 tick;
  logic                 sd_sel;
  logic                 cap;
  logic                 last;
  logic                 slot_high;
  logic                 emit_ok;
  logic                 unused_attr;

  assign cfg         = decode_attr(rx_attr);
  assign unused_attr = ^{rx_attr[31:24], rx_attr[19:16], rx_attr[7]};

  sarx_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({sck, ws, sd}),
    .dout (sync_out)
  );

  assign {sck_s, ws_s, sd_s} = sync_out;

  always_ff @(posedge clk) begin
    if (rst) sck_d_q <= 1'b0;
    else     sck_d_q <= sck_s;
  end

  assign tick = sck_s & ~sck_d_q;

  always_comb begin
    sd_sel = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (cfg.src == 4'(i)) sd_sel = sd_s[i];
    end
  end

  sarx_slot_ctrl #(.CNT_W(CNT_W), .LO_W(LO_W), .HI_W(HI_W)) i_slot (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .ws_s      (ws_s),
    .en        (rx_en),
    .cfg       (cfg),
    .cap       (cap),
    .last      (last),
    .slot_high (slot_high)
  );

  assign emit_ok = cfg.pcm | ~cfg.mono | ~slot_high;

  sarx_assembler #(.DATA_W(DATA_W), .LO_W(LO_W), .HI_W(HI_W)) i_asm (
    .clk       (clk),
    .rst       (rst),
    .cap       (cap),
    .last      (last),
    .bit_in    (sd_sel),
    .wide      (cfg.wide & ~cfg.pcm),
    .emit_ok   (emit_ok),
    .chan      (slot_high & ~cfg.pcm),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_right (out_right)
  );

endmodule

// File: rtl/sarx_checker.sv
module sarx_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_en,
  input logic [31:0]       rx_attr,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_right
);

  // R9
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0 && !out_right));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R6
  idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !out_valid);

  // R3
  mono_left_only_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(rx_attr[6:4]) == 3'b001) |-> !out_right);

  // R1
  pcm_flag_low_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(rx_attr[1:0]) == 2'b01) |-> !out_right);

  // R2
  sext16_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ($past(rx_attr[1:0]) == 2'b01 || $past(rx_attr[3:2]) != 2'b10))
      |-> ((&out_data[DATA_W-1:15]) || !(|out_data[DATA_W-1:15])));

  // R2
  sext24_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((&out_data[DATA_W-1:23]) || !(|out_data[DATA_W-1:23])));

endmodule

bind serial_audio_rx sarx_checker #(.DATA_W(DATA_W)) i_sarx_checker (
  .clk       (clk),
  .rst       (rst),
  .rx_en     (rx_en),
  .rx_attr   (rx_attr),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_right (out_right)
);

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;

  localparam int NL   = 4;
  localparam int SLOT = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_en = 1'b0;
  logic [31:0]   rx_attr = '0;
  logic          sck = 1'b0;
  logic          ws = 1'b0;
  logic [NL-1:0] sd = '0;
  logic          out_valid;
  logic [31:0]   out_data;
  logic          out_right;

  int checks = 0;
  int failures = 0;
  int drv_line = 0;
  bit finished = 0;

  logic [31:0] got_d[$];
  logic        got_c[$];
  logic [31:0] exp_d[$];
  logic        exp_c[$];

  always #4 clk = ~clk;

  serial_audio_rx i_serial_audio_rx (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rx_attr(rx_attr),
    .sck(sck), .ws(ws), .sd(sd),
    .out_valid(out_valid), .out_data(out_data), .out_right(out_right)
  );

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      got_d.push_back(out_data);
      got_c.push_back(out_right);
    end
  end

  function automatic logic [31:0] sx16(input logic [23:0] v);
    return {{16{v[15]}}, v[15:0]};
  endfunction

  function automatic logic [31:0] sx24(input logic [23:0] v);
    return {{8{v[23]}}, v[23:0]};
  endfunction

  function automatic logic [31:0] mk_attr(input logic [1:0] md, input logic [1:0] pr,
                                          input logic [2:0] ch, input logic [7:0] off,
                                          input logic [3:0] src);
    return {8'h00, src, 4'h0, off, 1'b0, ch, pr, md};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic w, input logic d);
    @(negedge clk);
    ws = w;
    for (int i = 0; i < NL; i++) sd[i] = (i == drv_line) ? d : ~d;
    sck = 1'b0;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic i2s_slot(input logic w, input logic [23:0] smp, input int prec,
                          input int off, input logic junk, input int en_at);
    for (int p = 0; p < SLOT; p++) begin
      if (p == en_at) begin
        @(negedge clk);
        rx_en = 1'b1;
      end
      if (p >= off && p - off < prec) bit_out(w, smp[prec-1-(p-off)]);
      else                            bit_out(w, junk);
    end
  endtask

  task automatic pcm_frame(input logic [15:0] smp, input int off, input logic junk);
    for (int p = 0; p < SLOT; p++) begin
      if (p >= off && p - off < 16) bit_out(p == 0, smp[15-(p-off)]);
      else                          bit_out(p == 0, junk);
    end
  endtask

  task automatic start_run(input logic [31:0] attr, input logic en, input logic prime_ws);
    @(negedge clk);
    rx_en = 1'b0;
    rx_attr = attr;
    got_d.delete(); got_c.delete(); exp_d.delete(); exp_c.delete();
    bit_out(prime_ws, 1'b0);
    @(negedge clk);
    rx_en = en;
    bit_out(prime_ws, 1'b0);
    bit_out(prime_ws, 1'b0);
  endtask

  task automatic end_run(input string tag, input logic tail_ws);
    bit_out(tail_ws, 1'b0);
    bit_out(tail_ws, 1'b0);
    repeat (6) @(negedge clk);
    rx_en = 1'b0;
    check({tag, " word count"}, got_d.size(), exp_d.size());
    for (int k = 0; k < exp_d.size() && k < got_d.size(); k++) begin
      check({tag, " data"}, got_d[k], exp_d[k]);
      check({tag, " channel"}, {31'b0, got_c[k]}, {31'b0, exp_c[k]});
    end
  endtask

  task automatic expect_word(input logic [31:0] d, input logic c);
    exp_d.push_back(d);
    exp_c.push_back(c);
  endtask

  // R1 R3 R4 R7 R8: standard I2S, 16-bit stereo, junk ones outside the window
  task automatic t_i2s_std16();
    start_run(mk_attr(2'b00, 2'b01, 3'b010, 8'd1, 4'd0), 1'b1, 1'b1);
    i2s_slot(1'b0, 24'h008001, 16, 1, 1'b1, -1); expect_word(sx16(24'h8001), 1'b0);
    i2s_slot(1'b1, 24'h001234, 16, 1, 1'b1, -1); expect_word(sx16(24'h1234), 1'b1);
    i2s_slot(1'b0, 24'h007FFF, 16, 1, 1'b1, -1); expect_word(sx16(24'h7FFF), 1'b0);
    i2s_slot(1'b1, 24'h00FFFE, 16, 1, 1'b1, -1); expect_word(sx16(24'hFFFE), 1'b1);
    end_run("R1/R3/R4/R7 i2s std16", 1'b0);
  endtask

  // R2 R4: left-justified (offset 0), 24-bit stereo
  task automatic t_i2s_lj24();
    start_run(mk_attr(2'b00, 2'b10, 3'b010, 8'd0, 4'd0), 1'b1, 1'b1);
    i2s_slot(1'b0, 24'hA5A5A5, 24, 0, 1'b1, -1); expect_word(sx24(24'hA5A5A5), 1'b0);
    i2s_slot(1'b1, 24'h012345, 24, 0, 1'b0, -1); expect_word(sx24(24'h012345), 1'b1);
    end_run("R2/R4 i2s lj24", 1'b0);
  endtask

  // R3: mono keeps only the word-select-low slot
  task automatic t_mono();
    start_run(mk_attr(2'b00, 2'b01, 3'b001, 8'd1, 4'd0), 1'b1, 1'b1);
    i2s_slot(1'b0, 24'h000F0F, 16, 1, 1'b0, -1); expect_word(sx16(24'h0F0F), 1'b0);
    i2s_slot(1'b1, 24'h001111, 16, 1, 1'b0, -1);
    i2s_slot(1'b0, 24'h00F00F, 16, 1, 1'b0, -1); expect_word(sx16(24'hF00F), 1'b0);
    i2s_slot(1'b1, 24'h002222, 16, 1, 1'b0, -1);
    end_run("R3 mono", 1'b0);
  endtask

  // R1 R2: PCM, precision field asks for 24 but 16 is used
  task automatic t_pcm(input int off);
    start_run(mk_attr(2'b01, 2'b10, 3'b010, 8'(off), 4'd0), 1'b1, 1'b0);
    pcm_frame(16'hBEEF, off, 1'b1); expect_word(sx16(24'hBEEF), 1'b0);
    pcm_frame(16'h0102, off, 1'b1); expect_word(sx16(24'h0102), 1'b0);
    end_run("R1/R2 pcm", 1'b0);
  endtask

  // R4: larger offset
  task automatic t_offset3();
    start_run(mk_attr(2'b00, 2'b01, 3'b010, 8'd3, 4'd0), 1'b1, 1'b1);
    i2s_slot(1'b0, 24'h00C3C3, 16, 3, 1'b1, -1); expect_word(sx16(24'hC3C3), 1'b0);
    i2s_slot(1'b1, 24'h003C3C, 16, 3, 1'b0, -1); expect_word(sx16(24'h3C3C), 1'b1);
    end_run("R4 offset3", 1'b0);
  endtask

  // R5: line selection and out-of-range index
  task automatic t_source();
    drv_line = 2;
    start_run(mk_attr(2'b00, 2'b01, 3'b010, 8'd1, 4'd2), 1'b1, 1'b1);
    i2s_slot(1'b0, 24'h005A3C, 16, 1, 1'b0, -1); expect_word(sx16(24'h5A3C), 1'b0);
    i2s_slot(1'b1, 24'h009876, 16, 1, 1'b0, -1); expect_word(sx16(24'h9876), 1'b1);
    end_run("R5 line2", 1'b0);
    start_run(mk_attr(2'b00, 2'b01, 3'b010, 8'd1, 4'd9), 1'b1, 1'b1);
    i2s_slot(1'b0, 24'h00FFFF, 16, 1, 1'b1, -1); expect_word(32'h0, 1'b0);
    i2s_slot(1'b1, 24'h00ABCD, 16, 1, 1'b1, -1); expect_word(32'h0, 1'b1);
    end_run("R5 line out of range", 1'b0);
    drv_line = 0;
  endtask

  // R6: disabled delivers nothing
  task automatic t_disabled();
    start_run(mk_attr(2'b00, 2'b01, 3'b010, 8'd1, 4'd0), 1'b0, 1'b1);
    i2s_slot(1'b0, 24'h001357, 16, 1, 1'b0, -1);
    i2s_slot(1'b1, 24'h002468, 16, 1, 1'b0, -1);
    end_run("R6 disabled", 1'b0);
  endtask

  // R6: enabling inside a slot waits for the next word edge
  task automatic t_late_enable();
    start_run(mk_attr(2'b00, 2'b01, 3'b010, 8'd1, 4'd0), 1'b0, 1'b1);
    i2s_slot(1'b0, 24'h001111, 16, 1, 1'b0, 6);
    i2s_slot(1'b1, 24'h00A0A0, 16, 1, 1'b0, -1); expect_word(sx16(24'hA0A0), 1'b1);
    i2s_slot(1'b0, 24'h000505, 16, 1, 1'b0, -1); expect_word(sx16(24'h0505), 1'b0);
    end_run("R6 late enable", 1'b1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    check("R9 reset valid", {31'b0, out_valid}, 32'h0);
    check("R9 reset data", out_data, 32'h0);
    check("R9 reset flag", {31'b0, out_right}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    t_i2s_std16();
    t_i2s_lj24();
    t_mono();
    t_pcm(1);
    t_pcm(0);
    t_offset3();
    t_source();
    t_disabled();
    t_late_enable();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

endmodule